// File: doc/BRIEF.md
# Serial Command Register Front-End

This block is a bus-slave register bank that lets a host processor launch register accesses to up to four peripheral chips that share one serial shifter. The host programs a direction flag, a peripheral register address and write data, then launches the access by inverting the peripheral's bit in a chip-select register. A read-modify-write of that register with an XOR mask is enough. A change in either direction launches the access.

The bank compares the chip-select register with a copy of itself taken one clock earlier. When it finds a change and no access is pending, it latches the direction, address and write data. It then sends a one-cycle start pulse with those fields to the shifter. A busy flag stays set until the shifter answers with a one-cycle done pulse. For a read access, the data returned with done is captured in a read-only register.

The command output is a valid-only stream with no back-pressure. `cmd_start` is valid for exactly one cycle, and the shifter must accept it in that cycle. The bank keeps the fields steady until done, and starts nothing else while busy.

Top module: `spi_cmd_regbank`

## Requirements
- R1: After reset, every readable word (offsets 0 to 7) reads zero and `cmd_start` is low.
- R2: Each bus access with `wb_cyc` and `wb_stb` high is acknowledged with `wb_ack` high for exactly one cycle, in the cycle after it is sampled.
- R3: Word map, by word index on `wb_adr`: 0 control (bit 0 = direction, 1 = read, 0 = write), 1 status, 2 peripheral address (low 16 bits), 3 write data (32 bits), 4 read data, 5 chip select (low 4 bits, bit n = chip n). Bits outside these fields, and words 6 and 7, read as zero.
- R4: Writes to the status word and the read-data word are acknowledged and change nothing.
- R5: Inverting one chip-select bit while idle, in either direction, gives exactly one `cmd_start` pulse. The pulse comes two cycles after the write is sampled and carries that chip's index on `cmd_chip`, plus the direction, address and write data held in the bank.
- R6: When several chip-select bits change in one write, only the lowest-numbered changed chip gets a command.
- R7: The busy flag (status bit 0) rises together with `cmd_start`. It stays high until the cycle `eng_done` is seen and reads zero from the next cycle.
- R8: Chip-select changes made while busy start no command, either then or after busy clears.
- R9: While busy, `cmd_chip`, `cmd_rd`, `cmd_addr` and `cmd_wdata` hold their launch values even if the host rewrites the control, address or write-data words.
- R10: When a read command completes, `eng_rdata` in the done cycle becomes the read-data word. A completed write command leaves that word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_cyc | input | 1 | Bus cycle |
| wb_stb | input | 1 | Bus strobe |
| wb_we | input | 1 | Bus write enable |
| wb_adr | input | 3 | Word index (byte address bits 4:2) |
| wb_dat_i | input | 32 | Bus write data |
| wb_ack | output | 1 | Bus acknowledge |
| wb_dat_o | output | 32 | Bus read data |
| cmd_start | output | 1 | One-cycle command valid to the shifter |
| cmd_chip | output | 2 | Target chip index |
| cmd_rd | output | 1 | 1 = read access |
| cmd_addr | output | 16 | Peripheral register address |
| cmd_wdata | output | 32 | Peripheral write data |
| eng_done | input | 1 | One-cycle completion from the shifter |
| eng_rdata | input | 32 | Read data, valid with eng_done |

## Verification
A stale copy of the chip-select register would show up on the next write in one of two ways. Either a start pulse appears with no matching expectation in the scoreboard, or an expected pulse never arrives. Both are visible two cycles after the write. A busy flag stuck high or cleared early shows in the next status read, and as a second start pulse within the done window. Fields that are latched wrongly, or left open to later host writes, show up as a mismatch at the start pulse or at done. A capture done on the wrong condition shows as a wrong read-data word at the first readback after completion.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int WB_DW = 32;

  typedef enum logic [2:0] {
    RG_CTRL  = 3'd0,
    RG_STAT  = 3'd1,
    RG_PADDR = 3'd2,
    RG_WDATA = 3'd3,
    RG_RDATA = 3'd4,
    RG_CSEL  = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/scr_wb_regs.sv
module scr_wb_regs
  import scr_pkg::*;
#(
  parameter int WB_AW = 5,
  parameter int PAW   = 16,
  parameter int NCHIP = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wb_cyc,
  input  logic               wb_stb,
  input  logic               wb_we,
  input  logic [WB_AW-1:2]   wb_adr,
  input  logic [WB_DW-1:0]   wb_dat_i,
  output logic               wb_ack,
  output logic [WB_DW-1:0]   wb_dat_o,
  output logic               rd_flag,
  output logic [PAW-1:0]     paddr,
  output logic [WB_DW-1:0]   wdata,
  output logic [NCHIP-1:0]   csel,
  input  logic               busy,
  input  logic [WB_DW-1:0]   rdata
);
  localparam int IW = WB_AW - 2;

  logic          access, wr;
  logic [IW-1:0] idx;
  logic [WB_DW-1:0] rd_mux;

  assign access = wb_cyc & wb_stb & ~wb_ack;
  assign wr     = access & wb_we;
  assign idx    = wb_adr;

  always_comb begin
    rd_mux = '0;
    case (idx)
      IW'(RG_CTRL):  rd_mux[0]         = rd_flag;
      IW'(RG_STAT):  rd_mux[0]         = busy;
      IW'(RG_PADDR): rd_mux[PAW-1:0]   = paddr;
      IW'(RG_WDATA): rd_mux            = wdata;
      IW'(RG_RDATA): rd_mux            = rdata;
      IW'(RG_CSEL):  rd_mux[NCHIP-1:0] = csel;
      default:       rd_mux            = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_ack   <= 1'b0;
      wb_dat_o <= '0;
      rd_flag  <= 1'b0;
      paddr    <= '0;
      wdata    <= '0;
      csel     <= '0;
    end else begin
      wb_ack <= access;
      if (access) wb_dat_o <= rd_mux;
      if (wr) begin
        case (idx)
          IW'(RG_CTRL):  rd_flag <= wb_dat_i[0];
          IW'(RG_PADDR): paddr   <= wb_dat_i[PAW-1:0];
          IW'(RG_WDATA): wdata   <= wb_dat_i;
          IW'(RG_CSEL):  csel    <= wb_dat_i[NCHIP-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/scr_toggle_pick.sv
module scr_toggle_pick #(
  parameter int NCHIP = 4,
  parameter int CW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCHIP-1:0] csel,
  input  logic             busy,
  output logic             hit,
  output logic [CW-1:0]    hit_idx
);
  logic [NCHIP-1:0] csel_prev, diff;
  logic             found;

  assign diff = csel ^ csel_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) csel_prev <= '0;
    else        csel_prev <= csel;
  end

  // lowest-numbered changed bit wins
  always_comb begin
    found   = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < NCHIP; i++) begin
      if (diff[i] && !found) begin
        found   = 1'b1;
        hit_idx = CW'(i);
      end
    end
  end

  assign hit = found & ~busy;
endmodule

// File: rtl/scr_cmd_track.sv
module scr_cmd_track
  import scr_pkg::*;
#(
  parameter int PAW = 16,
  parameter int CW  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [CW-1:0]    hit_idx,
  input  logic             rd_flag,
  input  logic [PAW-1:0]   paddr,
  input  logic [WB_DW-1:0] wdata,
  input  logic             eng_done,
  input  logic [WB_DW-1:0] eng_rdata,
  output logic             cmd_start,
  output logic [CW-1:0]    cmd_chip,
  output logic             cmd_rd,
  output logic [PAW-1:0]   cmd_addr,
  output logic [WB_DW-1:0] cmd_wdata,
  output logic             busy,
  output logic [WB_DW-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_start <= 1'b0;
      cmd_chip  <= '0;
      cmd_rd    <= 1'b0;
      cmd_addr  <= '0;
      cmd_wdata <= '0;
      busy      <= 1'b0;
      rdata     <= '0;
    end else begin
      cmd_start <= hit;
      if (hit) begin
        busy      <= 1'b1;
        cmd_chip  <= hit_idx;
        cmd_rd    <= rd_flag;
        cmd_addr  <= paddr;
        cmd_wdata <= wdata;
      end else if (busy && eng_done) begin
        busy <= 1'b0;
        if (cmd_rd) rdata <= eng_rdata;
      end
    end
  end
endmodule

// File: rtl/spi_cmd_regbank.sv
module spi_cmd_regbank
  import scr_pkg::*;
#(
  parameter  int WB_AW = 5,
  parameter  int PAW   = 16,
  parameter  int NCHIP = 4,
  localparam int CW    = (NCHIP > 1) ? $clog2(NCHIP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wb_cyc,
  input  logic             wb_stb,
  input  logic             wb_we,
  input  logic [WB_AW-1:2] wb_adr,
  input  logic [WB_DW-1:0] wb_dat_i,
  output logic             wb_ack,
  output logic [WB_DW-1:0] wb_dat_o,
  output logic             cmd_start,
  output logic [CW-1:0]    cmd_chip,
  output logic             cmd_rd,
  output logic [PAW-1:0]   cmd_addr,
  output logic [WB_DW-1:0] cmd_wdata,
  input  logic             eng_done,
  input  logic [WB_DW-1:0] eng_rdata
);
  logic             rd_flag, busy, hit;
  logic [PAW-1:0]   paddr;
  logic [WB_DW-1:0] wdata, rdata;
  logic [NCHIP-1:0] csel;
  logic [CW-1:0]    hit_idx;

  scr_wb_regs #(.WB_AW(WB_AW), .PAW(PAW), .NCHIP(NCHIP)) u_regs (
    .clk(clk), .rst_n(rst_n), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
    .wb_adr(wb_adr), .wb_dat_i(wb_dat_i), .wb_ack(wb_ack), .wb_dat_o(wb_dat_o),
    .rd_flag(rd_flag), .paddr(paddr), .wdata(wdata), .csel(csel),
    .busy(busy), .rdata(rdata)
  );

  scr_toggle_pick #(.NCHIP(NCHIP), .CW(CW)) u_pick (
    .clk(clk), .rst_n(rst_n), .csel(csel), .busy(busy),
    .hit(hit), .hit_idx(hit_idx)
  );

  scr_cmd_track #(.PAW(PAW), .CW(CW)) u_track (
    .clk(clk), .rst_n(rst_n), .hit(hit), .hit_idx(hit_idx),
    .rd_flag(rd_flag), .paddr(paddr), .wdata(wdata),
    .eng_done(eng_done), .eng_rdata(eng_rdata),
    .cmd_start(cmd_start), .cmd_chip(cmd_chip), .cmd_rd(cmd_rd),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .rdata(rdata)
  );
endmodule

// File: rtl/spi_cmd_regbank_chk.sv
module spi_cmd_regbank_chk #(
  parameter int PAW = 16,
  parameter int CW  = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wb_cyc,
  input logic           wb_stb,
  input logic           wb_ack,
  input logic           cmd_start,
  input logic [CW-1:0]  cmd_chip,
  input logic           cmd_rd,
  input logic [PAW-1:0] cmd_addr,
  input logic [31:0]    cmd_wdata,
  input logic           eng_done,
  input logic           busy
);
  // R2
  ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc && wb_stb && !wb_ack) |=> wb_ack);
  // R2
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ack |=> !wb_ack);
  // R7
  busy_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> busy);
  // R7
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_done) |=> !busy);
  // R8
  no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !cmd_start);
  // R9
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmd_start) |-> $stable({cmd_chip, cmd_rd, cmd_addr, cmd_wdata}));
endmodule

bind spi_cmd_regbank spi_cmd_regbank_chk #(.PAW(PAW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_ack(wb_ack),
  .cmd_start(cmd_start), .cmd_chip(cmd_chip), .cmd_rd(cmd_rd),
  .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .eng_done(eng_done), .busy(busy)
);

// File: tb/tb_spi_cmd_regbank.sv
module tb_spi_cmd_regbank;
  localparam int PAW = 16, CW = 2, LAT = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
  logic [4:2] wb_adr = '0;
  logic [31:0] wb_dat_i = '0, wb_dat_o, cmd_wdata, eng_rdata = '0;
  logic wb_ack, cmd_start, cmd_rd, eng_done = 1'b0;
  logic [CW-1:0] cmd_chip;
  logic [PAW-1:0] cmd_addr;

  spi_cmd_regbank dut (
    .clk(clk), .rst_n(rst_n), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
    .wb_adr(wb_adr), .wb_dat_i(wb_dat_i), .wb_ack(wb_ack), .wb_dat_o(wb_dat_o),
    .cmd_start(cmd_start), .cmd_chip(cmd_chip), .cmd_rd(cmd_rd),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .eng_done(eng_done), .eng_rdata(eng_rdata)
  );

  typedef struct packed {
    logic [CW-1:0]  chip;
    logic           rd;
    logic [PAW-1:0] addr;
    logic [31:0]    wdata;
  } cmd_t;

  cmd_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] reply(input logic [CW-1:0] c, input logic [PAW-1:0] a);
    return 32'h5A00_0000 | (32'(c) << 20) | 32'(a);
  endfunction

  // shifter model: answers LAT cycles after the start pulse
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && cmd_start) begin
        cmd_t got;
        got = '{cmd_chip, cmd_rd, cmd_addr, cmd_wdata};
        repeat (LAT - 1) @(negedge clk);
        chk({cmd_chip, cmd_rd, cmd_addr, cmd_wdata} == got,
            "R9 fields held until done", cmd_addr, got.addr);
        eng_rdata = reply(got.chip, got.addr);
        eng_done  = 1'b1;
        @(negedge clk);
        eng_done  = 1'b0;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && cmd_start) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 start with no expectation", 32'(cmd_chip), 32'hFFFF_FFFF);
      end else begin
        cmd_t e;
        e = exp_q.pop_front();
        chk(cmd_chip == e.chip, "R5/R6 cmd_chip", 32'(cmd_chip), 32'(e.chip));
        chk(cmd_rd == e.rd, "R5 cmd_rd", 32'(cmd_rd), 32'(e.rd));
        chk(cmd_addr == e.addr, "R5 cmd_addr", 32'(cmd_addr), 32'(e.addr));
        chk(cmd_wdata == e.wdata, "R5 cmd_wdata", cmd_wdata, e.wdata);
      end
    end
  end

  task automatic wb_xfer(input bit we, input int widx, input logic [31:0] d,
                         output logic [31:0] q);
    wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = we; wb_adr = 3'(widx); wb_dat_i = d;
    @(negedge clk);
    chk(wb_ack == 1'b1, "R2 ack in next cycle", 32'(wb_ack), 32'd1);
    q = wb_dat_o;
    wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0;
    @(negedge clk);
    chk(wb_ack == 1'b0, "R2 ack one cycle", 32'(wb_ack), 32'd0);
  endtask

  task automatic wr(input int widx, input logic [31:0] d);
    logic [31:0] unused_q;
    wb_xfer(1'b1, widx, d, unused_q);
  endtask

  task automatic rd(input int widx, output logic [31:0] q);
    wb_xfer(1'b0, widx, 32'h0, q);
  endtask

  task automatic kick(input int chip, input bit r, input logic [PAW-1:0] a,
                      input logic [31:0] d);
    logic [31:0] cur, s;
    wr(0, 32'(r));
    wr(2, 32'(a));
    wr(3, d);
    rd(5, cur);
    exp_q.push_back('{CW'(chip), r, a, d});
    wr(5, cur ^ (32'd1 << chip));
    rd(1, s);
    chk(s == 32'd1, "R7 busy after start", s, 32'd1);
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    s = 32'd1;
    for (int i = 0; i < 100 && s != 0; i++) rd(1, s);
    chk(s == 32'd0, "R7 busy cleared after done", s, 32'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] q, keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(cmd_start == 1'b0, "R1 no start after reset", 32'(cmd_start), 32'd0);
    for (int i = 0; i < 8; i++) begin
      rd(i, q);
      chk(q == 32'd0, "R1 word zero after reset", q, 32'd0);
    end

    // R3 field widths
    wr(0, 32'hFFFF_FFFF); rd(0, q); chk(q == 32'd1, "R3 control bit0 only", q, 32'd1);
    wr(2, 32'hFFFF_FFFF); rd(2, q); chk(q == 32'h0000_FFFF, "R3 address width", q, 32'h0000_FFFF);
    wr(3, 32'h1234_5678); rd(3, q); chk(q == 32'h1234_5678, "R3 write data", q, 32'h1234_5678);
    wr(6, 32'hFFFF_FFFF); rd(6, q); chk(q == 32'd0, "R3 unmapped word", q, 32'd0);

    // R6 all chip bits flip at once: only chip 0 served
    exp_q.push_back('{CW'(0), 1'b1, 16'hFFFF, 32'h1234_5678});
    wr(5, 32'hFFFF_FFFF);
    rd(5, q); chk(q == 32'h0000_000F, "R3 chip select width", q, 32'hF);
    wait_idle();
    rd(4, q); chk(q == reply(0, 16'hFFFF), "R10 read captured", q, reply(0, 16'hFFFF));

    // R4 read-only words
    keep = q;
    wr(1, 32'hFFFF_FFFF); wr(4, 32'h0);
    rd(1, q); chk(q == 32'd0, "R4 status unwritable", q, 32'd0);
    rd(4, q); chk(q == keep, "R4 read data unwritable", q, keep);

    // R5 write commands, falling then rising bit
    kick(2, 1'b0, 16'h0123, 32'hDEAD_BEEF); wait_idle();
    rd(4, q); chk(q == keep, "R10 write leaves read data", q, keep);
    kick(2, 1'b0, 16'h0321, 32'hCAFE_F00D); wait_idle();

    // R5/R10 read command
    kick(1, 1'b1, 16'h0456, 32'h0); wait_idle();
    rd(4, q); chk(q == reply(1, 16'h0456), "R10 read chip1", q, reply(1, 16'h0456));

    // R8 toggle while busy is dropped
    kick(3, 1'b1, 16'h0789, 32'h1); 
    rd(5, q); wr(5, q ^ 32'd1);
    wait_idle();
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R8 no pending expectation", 32'(exp_q.size()), 32'd0);
    rd(4, q); chk(q == reply(3, 16'h0789), "R10 read chip3", q, reply(3, 16'h0789));

    // R9 rewrites while busy do not reach the command
    kick(1, 1'b1, 16'h0AAA, 32'h2);
    wr(2, 32'h5555); wr(3, 32'h7777_7777); wr(0, 32'h0);
    wait_idle();
    rd(4, q); chk(q == reply(1, 16'h0AAA), "R9 launch address used", q, reply(1, 16'h0AAA));

    repeat (5) @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule